// File: doc/BRIEF.md
# Fractional M/N:D clock generator

This block derives a slower output clock from a reference clock at a rational ratio. Over a frame of N reference cycles the output completes exactly M cycles, so its average frequency is Fin·M/N. A third setting, D, sets how many of the N reference cycles in each frame the output spends low, so the duty cycle is set by software rather than fixed at one half.

Software programs the block through three word registers on a plain 32-bit write/read bus clocked by the reference clock. The divisor is not written directly: the block is given the bitwise inverse of the difference N−M and recovers N by adding M back. A 13-bit phase accumulator advances by M modulo N on every reference cycle. The output is low while the phase is below D and high otherwise. Each wrap of the phase starts a new output cycle. Settings are checked before use. Unsafe combinations, or a cleared enable bit, keep the output low and the counters at zero. New values are picked up only at a frame boundary, so a running output never shows a truncated period.

Top module: `mnd_clkgen`

## Requirements
- R1: Register map by byte offset: 0x0 holds M in bits [8:0] and the enable in bit 31; 0x4 holds the N encoding in bits [12:0]; 0x8 holds D in bits [12:0]. All three can be written and read back. Unused bits, and offset 0xC, read as zero.
- R2: While rst_n is low at a rising clock edge, all registers clear and clk_out goes low.
- R3: The divisor is recovered as N = M + ~enc, taken modulo 2^13, where enc is bits [12:0] of the 0x4 register.
- R4: With a legal setting in which M and N share no factor, every frame of N reference cycles contains exactly M low-to-high transitions of clk_out.
- R5: With the same kind of setting, clk_out is low for exactly D cycles and high for N−D cycles in each frame.
- R6: Writing the enable with a legal setting while the block is idle starts a frame at the second rising edge after the write edge. The first cycle of every frame is low.
- R7: If N is not greater than 2·M, clk_out stays low.
- R8: If D is not strictly between M and N−M, clk_out stays low.
- R9: Clearing the enable forces clk_out low from the second rising edge after the write edge, and it stays low.
- R10: A change to M, N or D written during a frame leaves that frame unchanged and applies from the next frame. An illegal value written this way stops the output at the frame boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; also clocks the register bus |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Write strobe for the register bus |
| reg_addr | input | 4 | Byte offset of the register being accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| clk_out | output | 1 | Generated clock |

## Verification
A table of coprime M/N/D settings is used. It ranges from M=1, where each frame is a single period, to settings where several wraps fall in one frame and the spacing between wraps is uneven. Counting rising edges and low cycles over one aligned frame checks the accumulator modulus and the N decoding separately from the duty threshold. Settings that fail each legality test on its own separate R7 from R8. Writes made in the middle of a frame, followed by two frames counted back to back, show whether new values are applied at once or held until the frame boundary.

// File: rtl/mnd_pkg.sv
package mnd_pkg;
  localparam int DATA_W = 32;
  localparam int MW     = 9;
  localparam int NW     = 13;

  // Recover the divisor from its inverted-difference encoding.
  function automatic logic [NW-1:0] decode_n(logic [MW-1:0] m, logic [NW-1:0] enc);
    return NW'(m) + ~enc;
  endfunction

  // Setting is usable when N > 2M and M < D < N - M.
  function automatic logic cfg_legal(logic [MW-1:0] m, logic [NW-1:0] n, logic [NW-1:0] d);
    logic [NW:0] m_w, twice_m, d_plus_m;
    m_w      = (NW+1)'(m);
    twice_m  = m_w << 1;
    d_plus_m = {1'b0, d} + m_w;
    return ({1'b0, n} > twice_m) && ({1'b0, d} > m_w) && (d_plus_m < {1'b0, n});
  endfunction

  // One phase step: acc + m, folded back below n.
  function automatic logic [NW-1:0] phase_step(logic [NW-1:0] acc, logic [MW-1:0] m, logic [NW-1:0] n);
    logic [NW:0] s;
    s = {1'b0, acc} + (NW+1)'(m);
    if (s >= {1'b0, n}) s = s - {1'b0, n};
    return s[NW-1:0];
  endfunction
endpackage

// File: rtl/mnd_regs.sv
module mnd_regs
  import mnd_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              en,
  output logic [MW-1:0]     m,
  output logic [NW-1:0]     n_enc,
  output logic [NW-1:0]     d
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam logic [WIDX_W-1:0] IDX_M = WIDX_W'(0);
  localparam logic [WIDX_W-1:0] IDX_N = WIDX_W'(1);
  localparam logic [WIDX_W-1:0] IDX_D = WIDX_W'(2);

  logic [WIDX_W-1:0] widx;
  assign widx = addr[ADDR_W-1:2];

  logic unused_bits;
  assign unused_bits = ^{addr[1:0], wdata[DATA_W-2:NW]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= 1'b0;
      m     <= '0;
      n_enc <= '0;
      d     <= '0;
    end else if (we) begin
      if (widx == IDX_M) begin
        m  <= wdata[MW-1:0];
        en <= wdata[DATA_W-1];
      end
      if (widx == IDX_N) n_enc <= wdata[NW-1:0];
      if (widx == IDX_D) d     <= wdata[NW-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (widx == IDX_M) begin
      rdata[MW-1:0]   = m;
      rdata[DATA_W-1] = en;
    end else if (widx == IDX_N) begin
      rdata[NW-1:0] = n_enc;
    end else if (widx == IDX_D) begin
      rdata[NW-1:0] = d;
    end
  end

  // R1: a write to the duty register lands in the next cycle
  a_r1_duty_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && widx == IDX_D) |=> (d == $past(wdata[NW-1:0])));

  // R1: a write to the M register updates the enable bit
  a_r1_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && widx == IDX_M) |=> (en == $past(wdata[DATA_W-1])));
endmodule

// File: rtl/mnd_phase.sv
module mnd_phase
  import mnd_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [MW-1:0] m,
  input  logic [NW-1:0] n,
  input  logic [NW-1:0] d,
  output logic          clk_out,
  output logic          frame_end,
  output logic          running
);
  logic [MW-1:0] m_act;
  logic [NW-1:0] n_act, d_act;
  logic [NW-1:0] acc_q, fcnt_q;
  logic          run_q;
  logic          cfg_ok;

  assign cfg_ok    = en && cfg_legal(m, n, d);
  assign frame_end = run_q && (fcnt_q == n_act - NW'(1));
  assign running   = run_q;
  assign clk_out   = run_q && (acc_q >= d_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      acc_q  <= '0;
      fcnt_q <= '0;
      m_act  <= '0;
      n_act  <= '0;
      d_act  <= '0;
    end else if (!en) begin
      run_q  <= 1'b0;
      acc_q  <= '0;
      fcnt_q <= '0;
    end else if (!run_q || frame_end) begin
      m_act  <= m;
      n_act  <= n;
      d_act  <= d;
      run_q  <= cfg_ok;
      acc_q  <= '0;
      fcnt_q <= '0;
    end else begin
      acc_q  <= phase_step(acc_q, m_act, n_act);
      fcnt_q <= fcnt_q + NW'(1);
    end
  end

  // R4: the phase never leaves the range below the divisor
  a_r4_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (acc_q < n_act));

  // R7 and R8: the generator only runs on a legal setting
  a_r8_run_legal: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> cfg_legal(m_act, n_act, d_act));

  // R9: a cleared enable silences the output on the next cycle
  a_r9_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !clk_out);

  // R10: active settings stay fixed inside a frame
  a_r10_hold_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && en && !frame_end) |=> ($stable(m_act) && $stable(n_act) && $stable(d_act)));

  // R6: each frame opens with a low cycle
  a_r6_frame_opens_low: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && en) |=> !clk_out);
endmodule

// File: rtl/mnd_clkgen.sv
module mnd_clkgen
  import mnd_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              clk_out
);
  logic          cfg_en;
  logic [MW-1:0] cfg_m;
  logic [NW-1:0] cfg_nenc, cfg_d, cfg_n;
  logic          frame_end, running;

  mnd_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .en    (cfg_en),
    .m     (cfg_m),
    .n_enc (cfg_nenc),
    .d     (cfg_d)
  );

  // R3: divisor recovered from the inverted difference
  assign cfg_n = decode_n(cfg_m, cfg_nenc);

  mnd_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_en),
    .m         (cfg_m),
    .n         (cfg_n),
    .d         (cfg_d),
    .clk_out   (clk_out),
    .frame_end (frame_end),
    .running   (running)
  );

  // R2: output low while idle
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !clk_out);

  // R6: a frame boundary only occurs while running
  a_r6_boundary_running: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> running);
endmodule

// File: tb/test_mnd_clkgen.sv
module test_mnd_clkgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        clk_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mnd_clkgen i_mnd_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .clk_out   (clk_out)
  );

  // {M, N, D}: coprime, legal settings
  localparam int VEC [8][3] = '{
    '{1, 4, 2}, '{3, 8, 4}, '{5, 16, 7}, '{3, 10, 5},
    '{7, 64, 20}, '{11, 100, 40}, '{1, 7, 3}, '{2, 9, 4}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  function automatic logic [31:0] enc_n(int m, int n);
    return 32'(~(n - m)) & 32'h1FFF;
  endfunction

  // Load a setting while idle, then enable; returns at the negedge after the write edge.
  task automatic setup(int m, int n, int d);
    wr(4'h0, 32'(m));
    wr(4'h4, enc_n(m, n));
    wr(4'h8, 32'(d));
    wr(4'h0, 32'h8000_0000 | 32'(m));
  endtask

  // Sample n cycles; count rising edges and low cycles.
  task automatic window(int n, output int rises, output int lows, output int first);
    logic prev;
    rises = 0; lows = 0; prev = 1'b0; first = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) first = int'(clk_out);
      if (!clk_out) lows++;
      if (i > 0 && clk_out && !prev) rises++;
      prev = clk_out;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int r, l, f, highs;

    // R2: reset state
    repeat (3) @(negedge clk);
    chk("R2 out in reset", int'(clk_out), 0);
    rst_n = 1'b1;
    rd(4'h0, v); chk("R2 M reg after reset", int'(v), 0);
    rd(4'h4, v); chk("R2 N reg after reset", int'(v), 0);
    rd(4'h8, v); chk("R2 D reg after reset", int'(v), 0);

    // R1: field widths and holes
    wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, v); chk("R1 M reg fields", int'(v), int'(32'h8000_01FF));
    wr(4'h0, 32'h0);
    wr(4'h4, 32'hFFFF_FFFF); rd(4'h4, v); chk("R1 N reg fields", int'(v), 32'h1FFF);
    wr(4'h8, 32'hFFFF_FFFF); rd(4'h8, v); chk("R1 D reg fields", int'(v), 32'h1FFF);
    wr(4'hC, 32'hFFFF_FFFF); rd(4'hC, v); chk("R1 hole reads zero", int'(v), 0);

    // R3, R4, R5, R6: table of settings
    for (int k = 0; k < 8; k++) begin
      setup(VEC[k][0], VEC[k][1], VEC[k][2]);
      window(VEC[k][1], r, l, f);
      chk($sformatf("R4 R3 rises M=%0d N=%0d", VEC[k][0], VEC[k][1]), r, VEC[k][0]);
      chk($sformatf("R5 lows M=%0d N=%0d D=%0d", VEC[k][0], VEC[k][1], VEC[k][2]), l, VEC[k][2]);
      chk("R6 frame opens low", f, 0);
      wr(4'h0, 32'h0);
    end

    // R7: N not above 2M (M=4, N=8, D=5)
    setup(4, 8, 5);
    window(40, r, l, f); chk("R7 N<=2M stays low", l, 40);
    wr(4'h0, 32'h0);

    // R8: D at M (M=3, N=10, D=3) and D at N-M (D=7)
    setup(3, 10, 3);
    window(30, r, l, f); chk("R8 D=M stays low", l, 30);
    wr(4'h0, 32'h0);
    setup(3, 10, 7);
    window(30, r, l, f); chk("R8 D=N-M stays low", l, 30);
    wr(4'h0, 32'h0);

    // R9: clear enable while running
    setup(3, 8, 4);
    window(3, r, l, f);
    wr(4'h0, 32'd3);
    window(24, r, l, f); chk("R9 disabled output low", l, 24);

    // R10: D changed mid-frame, then an illegal D mid-frame
    setup(3, 10, 5);
    l = 0; highs = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == 2)  begin reg_we = 1'b1; reg_addr = 4'h8; reg_wdata = 32'd6; end
      if (i == 3)  reg_we = 1'b0;
      if (i == 22) begin reg_we = 1'b1; reg_addr = 4'h8; reg_wdata = 32'd8; end
      if (i == 23) reg_we = 1'b0;
      if (!clk_out) l++;
      if (i == 9)  begin chk("R10 old D holds in frame", l, 5); l = 0; end
      if (i == 19) begin chk("R10 new D in next frame", l, 6); l = 0; end
      if (i == 29) begin chk("R10 frame finishes before illegal D", l, 6); l = 0; end
      if (i >= 30 && clk_out) highs++;
    end
    chk("R10 illegal D stops at boundary", highs, 0);

    // R2: reset while running
    setup(1, 4, 2);
    window(2, r, l, f);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); chk("R2 out low after reset", int'(clk_out), 0);
    rst_n = 1'b1;
    rd(4'h0, v); chk("R2 enable cleared by reset", int'(v), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule